// File: doc/BRIEF.md
# Line Black-Level Clamp with Output Blanking

This block sits behind the converter of an imaging front end. It holds a 12-bit pixel stream at a chosen black level. Each line, the sensor's shielded pixels arrive while a clamp-window strobe is active. During that window the block measures how far the corrected sample is from a programmable 8-bit black target. A fraction of that distance is subtracted from a signed correction word, which drives an offset DAC ahead of the converter. In this digital model, the correction is added to the raw sample. Outside the window the correction is frozen, so the effective pixels of the line all see the same offset.

A blanking strobe forces the pixel output to zero. The clamp window always wins over blanking. Both strobes share one polarity bit. A second configuration bit picks whether a sample is taken on the rising clock edge or on the falling edge before it. When the loop is switched off, the correction stops moving and the black target is added to every sample as a fixed offset. Every sample leaves the block exactly nine clock edges after it is captured. The target, enable and polarity travel with the sample they were captured beside.

Top module: `black_level_clamp`

## Requirements
- R1: While reset is asserted, and for the first nine rising edges after it is released, `pixOut` reads 0. Immediately after reset, `corrOut` reads 0.
- R2: A sample captured at rising edge k appears on `pixOut` after rising edge k+9 as 12-bit straight binary.
- R3: With the loop enabled and the window active, let y be the corrected sample and t the black target. The correction becomes its old value minus floor((y − t) / 4). The shift of 2 is the default of `ERR_SHIFT`. `corrOut` shows the new value after the next rising edge.
- R4: The correction saturates at −255 and +255 (default `CORR_LIM`).
- R5: With the window inactive, the correction keeps its value.
- R6: The corrected sample y is the raw sample plus the offset, clipped to the range 0 to 4095. With the loop enabled, the offset is the correction word.
- R7: A sample captured with blanking active and the window inactive is output as 0.
- R8: A sample captured with both window and blanking active is output as y, and the loop still updates from it.
- R9: With `activeHigh` = 1, the window and blanking strobes are active when high. With `activeHigh` = 0, they are active when low.
- R10: With `loopEn` = 0, the offset is the black target (zero-extended), and the correction holds its value even inside the window.
- R11: With `fallEdge` = 0, the sample is taken from `pixIn` at the rising edge. With `fallEdge` = 1, it is the value `pixIn` had at the preceding falling edge.
- R12: The target, loop enable and polarity that apply to a sample are the values present at the same rising edge that captures that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixIn | input | 12 | Raw converter sample |
| winIn | input | 1 | Clamp-window strobe (polarity per `activeHigh`) |
| blankIn | input | 1 | Blanking strobe (polarity per `activeHigh`) |
| activeHigh | input | 1 | 1: strobes active high; 0: active low |
| fallEdge | input | 1 | 1: take the sample at the falling edge |
| loopEn | input | 1 | 1: clamp loop on; 0: target used as a fixed offset |
| blackRef | input | 8 | Black target, 0 to 255 LSB |
| pixOut | output | 12 | Corrected, blanked pixel, 9 edges after capture |
| corrOut | output | 9 | Signed correction word for the offset DAC |

## Verification
The correction register is the only long-lived state. A wrong update step or a missing saturation shows on `corrOut` one edge after the window sample that caused it. The same error reaches `pixOut` nine edges later as a shifted offset on every following pixel of the line. A wrong priority between blanking and window, a wrong polarity decode or an off-by-one in the delay line shows as a mismatch on `pixOut` at exactly edge k+9. The bench therefore compares both outputs on every single cycle against an arithmetic model. This catches a fault within one line.

// File: rtl/lineclamp_pkg.sv
package lineclamp_pkg;

  // Strobes passed from the control capture to the datapath, aligned to the
  // sample register.
  typedef struct packed {
    logic useLoop;    // loop enabled for this sample
    logic winActive;  // clamp window decoded active
    logic zeroOut;    // blank this sample
  } clampStrobes_t;

endpackage

// File: rtl/lineclamp_ctrl.sv
module lineclamp_ctrl
  import lineclamp_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          winIn,
  input  logic          blankIn,
  input  logic          activeHigh,
  input  logic          loopEn,
  output clampStrobes_t strobe
);

  logic winQ;
  logic blankQ;
  logic enQ;

  // Polarity decode happens at capture, so each sample carries its own mode.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winQ   <= 1'b0;
      blankQ <= 1'b0;
      enQ    <= 1'b0;
    end else begin
      winQ   <= (winIn == activeHigh);
      blankQ <= (blankIn == activeHigh);
      enQ    <= loopEn;
    end
  end

  // The window takes priority over blanking.
  always_comb begin
    strobe.useLoop   = enQ;
    strobe.winActive = winQ;
    strobe.zeroOut   = blankQ & ~winQ;
  end

endmodule

// File: rtl/lineclamp_datapath.sv
module lineclamp_datapath
  import lineclamp_pkg::*;
#(
  parameter int PIX_W     = 12,
  parameter int REF_W     = 8,
  parameter int CORR_LIM  = 255,
  parameter int CORR_W    = 9,
  parameter int ERR_SHIFT = 2,
  parameter int LATENCY   = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PIX_W-1:0]         pixIn,
  input  logic                     fallEdge,
  input  logic [REF_W-1:0]         blackRef,
  input  clampStrobes_t            strobe,
  output logic [PIX_W-1:0]         pixOut,
  output logic signed [CORR_W-1:0] corrOut
);

  localparam int SW = PIX_W + 3;
  localparam logic signed [SW-1:0] PIX_MAX_S = SW'((1 << PIX_W) - 1);
  localparam logic signed [SW-1:0] LIM_S     = SW'(CORR_LIM);

  logic [PIX_W-1:0]         negCap;
  logic [PIX_W-1:0]         pixQ;
  logic [REF_W-1:0]         refQ;
  logic signed [CORR_W-1:0] corrQ;
  logic signed [CORR_W-1:0] corrNext;
  logic                     loopRun;

  logic signed [SW-1:0] pixS, refS, corrS, offS, sumS, errS, stepS, nextS, satS;
  logic [PIX_W-1:0]     yComb;
  logic [PIX_W-1:0]     stageIn;

  // Falling-edge capture for the alternate sampling edge.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negCap <= '0;
    else       negCap <= pixIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixQ <= '0;
      refQ <= '0;
    end else begin
      pixQ <= fallEdge ? negCap : pixIn;
      refQ <= blackRef;
    end
  end

  assign loopRun = strobe.useLoop & strobe.winActive;

  // Offset, clip, error and saturating integrator step.
  always_comb begin
    pixS  = $signed({{(SW-PIX_W){1'b0}}, pixQ});
    refS  = $signed({{(SW-REF_W){1'b0}}, refQ});
    corrS = $signed({{(SW-CORR_W){corrQ[CORR_W-1]}}, corrQ});
    offS  = strobe.useLoop ? corrS : refS;
    sumS  = pixS + offS;
    if (sumS < 0)              yComb = '0;
    else if (sumS > PIX_MAX_S) yComb = '1;
    else                       yComb = PIX_W'(sumS);
    errS  = $signed({{(SW-PIX_W){1'b0}}, yComb}) - refS;
    stepS = errS >>> ERR_SHIFT;
    nextS = corrS - stepS;
    if (nextS > LIM_S)       satS = LIM_S;
    else if (nextS < -LIM_S) satS = -LIM_S;
    else                     satS = nextS;
    corrNext = CORR_W'(satS);
    stageIn  = strobe.zeroOut ? '0 : yComb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        corrQ <= '0;
    else if (loopRun) corrQ <= corrNext;
  end

  // Output delay line, first stage holds the corrected sample.
  logic [PIX_W-1:0] pipe [LATENCY];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '0;
    else       pipe[0] <= stageIn;
  end

  for (genvar gi = 1; gi < LATENCY; gi++) begin : g_delay
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[gi] <= '0;
      else       pipe[gi] <= pipe[gi-1];
    end
  end

  assign pixOut  = pipe[LATENCY-1];
  assign corrOut = corrQ;

  // R4: correction never leaves the DAC range
  a_r4_corr_limit: assert property (@(posedge clk) disable iff (!rstN)
    (corrQ <= CORR_W'(CORR_LIM)) && (corrQ >= -CORR_W'(CORR_LIM)));

  // R5: correction frozen outside the window
  a_r5_hold_outside: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.winActive |=> $stable(corrQ));

  // R10: correction frozen with the loop disabled
  a_r10_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.useLoop |=> $stable(corrQ));

  // R3: a sample above target never raises the correction
  a_r3_direction: assert property (@(posedge clk) disable iff (!rstN)
    (loopRun && errS > 0) |=> corrQ <= $past(corrQ));

  // R7: blanked sample enters the delay line as zero
  a_r7_blank_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroOut |=> pipe[0] == '0);

  // R8: window sample is never blanked
  a_r8_window_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobe.winActive |=> pipe[0] == $past(yComb));

endmodule

// File: rtl/black_level_clamp.sv
module black_level_clamp
  import lineclamp_pkg::*;
#(
  parameter int PIX_W     = 12,
  parameter int REF_W     = 8,
  parameter int CORR_LIM  = 255,
  parameter int ERR_SHIFT = 2,
  parameter int LATENCY   = 9,
  localparam int CORR_W   = $clog2(CORR_LIM + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PIX_W-1:0]         pixIn,
  input  logic                     winIn,
  input  logic                     blankIn,
  input  logic                     activeHigh,
  input  logic                     fallEdge,
  input  logic                     loopEn,
  input  logic [REF_W-1:0]         blackRef,
  output logic [PIX_W-1:0]         pixOut,
  output logic signed [CORR_W-1:0] corrOut
);

  clampStrobes_t strobe;

  lineclamp_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .winIn      (winIn),
    .blankIn    (blankIn),
    .activeHigh (activeHigh),
    .loopEn     (loopEn),
    .strobe     (strobe)
  );

  lineclamp_datapath #(
    .PIX_W     (PIX_W),
    .REF_W     (REF_W),
    .CORR_LIM  (CORR_LIM),
    .CORR_W    (CORR_W),
    .ERR_SHIFT (ERR_SHIFT),
    .LATENCY   (LATENCY)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .pixIn    (pixIn),
    .fallEdge (fallEdge),
    .blackRef (blackRef),
    .strobe   (strobe),
    .pixOut   (pixOut),
    .corrOut  (corrOut)
  );

endmodule

// File: tb/test_black_level_clamp.sv
module test_black_level_clamp;

  localparam int CLK_HALF = 4;  // 125 MHz

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [11:0]       pixIn = '0;
  logic              winIn = 1'b0;
  logic              blankIn = 1'b0;
  logic              activeHigh = 1'b1;
  logic              fallEdge = 1'b0;
  logic              loopEn = 1'b1;
  logic [7:0]        blackRef = '0;
  logic [11:0]       pixOut;
  logic signed [8:0] corrOut;

  black_level_clamp i_black_level_clamp (
    .clk        (clk),
    .rstN       (rstN),
    .pixIn      (pixIn),
    .winIn      (winIn),
    .blankIn    (blankIn),
    .activeHigh (activeHigh),
    .fallEdge   (fallEdge),
    .loopEn     (loopEn),
    .blackRef   (blackRef),
    .pixOut     (pixOut),
    .corrOut    (corrOut)
  );

  always #CLK_HALF clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench configuration applied on each cycle
  bit    pol = 1'b1;
  bit    en = 1'b1;
  bit    fe = 1'b0;
  int    refv = 0;
  string tag = "R2";

  // model state
  int cModel = 0;
  int edgeNo = 0;
  int expPix [16];
  int expCor [16];

  function automatic int clip(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic check(string t, string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d (edge %0d)", t, what, got, exp, edgeNo);
    end
  endtask

  // One sample: a is on pixIn at the falling edge, b at the rising edge.
  task automatic cyc(int a, int b, bit w, bit bl);
    int s, off, y, o, pe, ce;
    pixIn      = 12'(a);
    winIn      = pol ? w : ~w;
    blankIn    = pol ? bl : ~bl;
    activeHigh = pol;
    loopEn     = en;
    fallEdge   = fe;
    blackRef   = 8'(refv);
    s   = fe ? a : b;
    off = en ? cModel : refv;
    y   = clip(s + off, 0, 4095);
    o   = (bl && !w) ? 0 : y;
    if (en && w) cModel = clip(cModel - ((y - refv) >>> 2), -255, 255);
    expPix[(edgeNo + 1) % 16] = o;
    expCor[(edgeNo + 1) % 16] = cModel;
    #4;
    pixIn = 12'(b);
    @(posedge clk);
    #1;
    edgeNo++;
    pe = (edgeNo - 9 <= 0) ? 0 : expPix[(edgeNo - 9) % 16];
    ce = (edgeNo - 1 <= 0) ? 0 : expCor[(edgeNo - 1) % 16];
    check(tag, "pixOut", int'(pixOut), pe);
    check(tag, "corrOut", int'(corrOut), ce);
  endtask

  initial begin
    int seed;
    for (int i = 0; i < 16; i++) begin expPix[i] = 0; expCor[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check("R1", "pixOut in reset", int'(pixOut), 0);
    check("R1", "corrOut in reset", int'(corrOut), 0);
    rstN = 1'b1;

    // R1 R2 R6: loop on, no window, zero correction passes samples unchanged
    tag = "R1 R2 R6"; refv = 64;
    for (int v = 0; v < 4096; v += 7) cyc(v, v, 0, 0);
    cyc(4095, 4095, 0, 0);

    // R3 R5: line loop with black window then active pixels
    tag = "R3 R5";
    for (int ln = 0; ln < 8; ln++) begin
      for (int i = 0; i < 20; i++) cyc(300 + i % 3, 300 + i % 3, 1, 0);
      for (int i = 0; i < 40; i++) cyc(500 + i * 50, 500 + i * 50, 0, 0);
    end

    // R4 R6: drive to both saturation limits and both clip rails
    tag = "R4 R6"; refv = 0;
    for (int i = 0; i < 60; i++) cyc(1000, 1000, 1, 0);
    for (int v = 0; v < 300; v += 20) cyc(v, v, 0, 0);
    refv = 255;
    for (int i = 0; i < 60; i++) cyc(0, 0, 1, 0);
    for (int v = 3700; v < 4096; v += 30) cyc(v, v, 0, 0);

    // R7 R8: blanking alone, then overlapping the window
    tag = "R7 R8"; refv = 64;
    for (int i = 0; i < 30; i++) cyc(i * 100, i * 100, 0, 1);
    for (int i = 0; i < 20; i++) cyc(310 + i, 310 + i, 1, 1);
    for (int i = 0; i < 10; i++) cyc(i * 300, i * 300, 0, 0);

    // R9: active-low strobes
    tag = "R9"; pol = 1'b0; refv = 100;
    for (int i = 0; i < 20; i++) cyc(150, 150, 1, 0);
    for (int i = 0; i < 15; i++) cyc(900 + i, 900 + i, 0, 1);
    for (int i = 0; i < 15; i++) cyc(700 + i, 700 + i, 0, 0);
    for (int i = 0; i < 10; i++) cyc(200, 200, 1, 1);
    pol = 1'b1;

    // R10: disabled loop, target as fixed offset, window has no effect
    tag = "R10"; en = 1'b0;
    for (int r = 0; r < 256; r += 5) begin
      refv = r;
      cyc(4000 - r * 3, 4000 - r * 3, (r % 10) == 0, 0);
      cyc(r * 7, r * 7, 1, 0);
    end
    refv = 255;
    cyc(4000, 4000, 0, 0);
    en = 1'b1;
    for (int i = 0; i < 10; i++) cyc(1234, 1234, 0, 0);

    // R11: sampling edge selection
    tag = "R11";
    for (int k = 0; k < 2; k++) begin
      fe = (k == 1);
      for (int i = 0; i < 40; i++) cyc((i * 97) % 4096, ((i * 97) % 4096) ^ 12'hA5A, 0, 0);
    end
    fe = 1'b0;

    // R12: all controls changing from sample to sample
    tag = "R12"; seed = 7;
    for (int i = 0; i < 2000; i++) begin
      int a, b;
      seed = seed * 1103515245 + 12345;
      a    = (seed >>> 4) & 4095;
      b    = (seed >>> 16) & 4095;
      refv = (seed >>> 8) & 255;
      pol  = seed[28];
      en   = seed[27] | seed[26];
      fe   = seed[25];
      cyc(a, b, seed[24] & seed[23], seed[22] & seed[21]);
    end
    pol = 1'b1; en = 1'b1; fe = 1'b0;
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(2 * CLK_HALF * 190000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired (edge %0d)", edgeNo);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule